// File: doc/BRIEF.md
# Paged System-Bus Address Decoder

This block sits between a CPU bus master and the memories and register blocks behind it. Each cycle it takes a 24-bit bus address and classifies its 4 KB page, so the page index is the top twelve address bits. The possible targets are work RAM, a peripheral register window on a secondary bus (the B-side window), a system register window (the A-side window), cartridge ROM and battery-backed save RAM. For memory pages it also reports the offset of the addressed byte within that memory and a memory-type code. It splits the A-side window further into controller-port, DMA-controller and internal-register strobes, with different rules for reads and writes.

Pages that nothing claims are flagged as missing. A read of such a page is answered by the decoder itself with a placeholder byte. A separate peek request reads without side effects. A peek of a register window or of an unmapped page gets a zero byte from the decoder and never strobes a peripheral. The cartridge is modelled as one flat ROM region plus one save-RAM bank. The ROM size and save-RAM size are parameters. All outputs are registered and follow the address presented one clock earlier.

Top module: `sysbus_page_decoder`

## Requirements
- R1: Banks 0x7E and 0x7F map 128 KB of work RAM linearly. The region is work RAM, the type code is 1, and the absolute address is {bank bit 0, addr[15:0]}.
- R2: In banks 0x00 to 0x3F and 0x80 to 0xBF, offsets 0x0000 to 0x1FFF mirror the first 8 KB of work RAM. The type code is 1 and the absolute address is addr[12:0].
- R3: In those same bank groups, offsets 0x2000 to 0x2FFF are the B-side register window. Its absolute address is 0xFFFFFFFF with type code 0. A read or write there (not a peek) raises sel_breg.
- R4: Offsets 0x4000 to 0x4FFF in those groups are the A-side window. A read of 0x4016 or 0x4017 raises sel_ctrl, a read at or above 0x4300 raises sel_dma, and any other read raises sel_ireg.
- R5: An A-side write to 0x4016 raises sel_ctrl. A write to 0x420B, to 0x420C or at or above 0x4300 raises sel_dma. Any other A-side write, 0x4017 included, raises sel_ireg.
- R6: Banks 0xC0 and above hold cartridge ROM when the page index {bank[5:0], addr[15:12]} is below ROM_PAGES (default 1024, which covers all of 0xC0 to 0xFF). The type code is 2 and the absolute address is addr[21:0].
- R7: Bank 0x70 holds save RAM in pages below SRAM_PAGES (default 8, so offsets 0x0000 to 0x7FFF). The type code is 3 and the absolute address is addr[15:0]. Higher pages of that bank are unmapped.
- R8: Every other page is unmapped. It gives a region of zero, type code 0 and absolute address 0xFFFFFFFF. A read or write raises map_miss. A read also returns fixed_data = addr[19:12] with fixed_vld set.
- R9: A peek (bus_peek high, which overrides bus_rd and bus_wr) raises no select strobe and no map_miss. When it targets a register window or an unmapped page, it returns fixed_data = 0 with fixed_vld set. A peek of a memory page leaves fixed_vld low.
- R10: All outputs are registered and reflect the inputs sampled at the previous rising edge. While rst is high every output is zero.
- R11: region_oh is one-hot or zero with bit 0 for work RAM, bit 1 for the B window, bit 2 for the A window, bit 3 for ROM and bit 4 for save RAM. At most one of sel_ctrl, sel_dma, sel_ireg and sel_breg is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | CPU bus address |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_peek | input | 1 | Side-effect-free read request |
| region_oh | output | 5 | One-hot target region |
| region_type | output | 2 | Memory type: 0 CPU/none, 1 work RAM, 2 ROM, 3 save RAM |
| abs_addr | output | 32 | Offset within the memory, all ones for non-memory pages |
| sel_ctrl | output | 1 | Controller-port strobe |
| sel_dma | output | 1 | DMA-controller strobe |
| sel_ireg | output | 1 | Internal-register strobe |
| sel_breg | output | 1 | B-side register window strobe |
| map_miss | output | 1 | Access to an unmapped page |
| fixed_vld | output | 1 | Decoder supplies the read byte |
| fixed_data | output | 8 | Placeholder or peek byte |

## Verification
The bench goes after several edges:
- The edges of the low-RAM mirror at 0x1FFF and 0x2000, and the boundary banks 0x3F, 0x80 and 0xBF. A decoder that copied a half-open bank loop would lose bank 0x3F.
- The unmapped gap at 0x3000 and the save-RAM page limit.
- The asymmetric A-side split: a write to 0x4017 belongs to the internal registers, a read of it to the controller, and 0x420B and 0x420C go to DMA only on writes. A shared read/write rule fails there.

Peeks are mixed into every region. A peek path that leaked strobes, flagged misses or returned the placeholder byte shows up at once. The random address stream is biased toward the mapped bank groups so that each rule is hit often.

// File: rtl/sysbus_dec_pkg.sv
package sysbus_dec_pkg;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_WRAM = 3'd1,
    RG_BREG = 3'd2,
    RG_AREG = 3'd3,
    RG_ROM  = 3'd4,
    RG_SRAM = 3'd5
  } region_e;

  localparam int NUM_RG = 5;

  typedef enum logic [1:0] {
    MT_CPU  = 2'd0,
    MT_WRAM = 2'd1,
    MT_ROM  = 2'd2,
    MT_SRAM = 2'd3
  } memtype_e;

  typedef enum logic [1:0] {
    AT_IREG = 2'd0,
    AT_CTRL = 2'd1,
    AT_DMA  = 2'd2
  } atgt_e;

endpackage

// File: rtl/sbd_page_map.sv
module sbd_page_map
  import sysbus_dec_pkg::*;
#(
  parameter int          PAGE_W     = 12,
  parameter int          PIDX_W     = 10,
  parameter logic [7:0]  WRAM_BANK  = 8'h7E,
  parameter logic [7:0]  SRAM_BANK  = 8'h70,
  parameter int          SRAM_PAGES = 8,
  parameter int          ROM_PAGES  = 1024
) (
  input  logic [PAGE_W-1:0] page,
  output region_e           region,
  output logic [PIDX_W-1:0] pidx
);
  localparam int MIRROR_PAGES = 2;

  logic [7:0] bank;
  logic [3:0] p4;
  logic       low_group;
  logic [9:0] rom_idx;

  assign bank      = page[PAGE_W-1 -: 8];
  assign p4        = page[3:0];
  assign low_group = ~bank[6];
  assign rom_idx   = {bank[5:0], p4};

  always_comb begin
    region = RG_NONE;
    pidx   = '0;
    if (bank[7:1] == WRAM_BANK[7:1]) begin
      region = RG_WRAM;
      pidx   = PIDX_W'({bank[0], p4});
    end else if (low_group) begin
      if (int'(p4) < MIRROR_PAGES) begin
        region = RG_WRAM;
        pidx   = PIDX_W'(p4);
      end else if (p4 == 4'h2) begin
        region = RG_BREG;
      end else if (p4 == 4'h4) begin
        region = RG_AREG;
      end
    end else if (bank == SRAM_BANK && int'(p4) < SRAM_PAGES) begin
      region = RG_SRAM;
      pidx   = PIDX_W'(p4);
    end else if (bank[7:6] == 2'b11 && int'(rom_idx) < ROM_PAGES) begin
      region = RG_ROM;
      pidx   = PIDX_W'(rom_idx);
    end
  end

endmodule

// File: rtl/sbd_abus_split.sv
module sbd_abus_split
  import sysbus_dec_pkg::*;
(
  input  logic [15:0] off,
  input  logic        is_wr,
  output atgt_e       tgt
);
  logic hi_dma;
  assign hi_dma = (off >= 16'h4300);

  always_comb begin
    tgt = AT_IREG;
    if (is_wr) begin
      if (off == 16'h4016)                                  tgt = AT_CTRL;
      else if (off == 16'h420B || off == 16'h420C || hi_dma) tgt = AT_DMA;
    end else begin
      if (off == 16'h4016 || off == 16'h4017)               tgt = AT_CTRL;
      else if (hi_dma)                                      tgt = AT_DMA;
    end
  end

endmodule

// File: rtl/sysbus_page_decoder.sv
module sysbus_page_decoder
  import sysbus_dec_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          ABS_W      = 32,
  parameter logic [7:0]  WRAM_BANK  = 8'h7E,
  parameter logic [7:0]  SRAM_BANK  = 8'h70,
  parameter int          SRAM_PAGES = 8,
  parameter int          ROM_PAGES  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_peek,
  output logic [4:0]        region_oh,
  output logic [1:0]        region_type,
  output logic [ABS_W-1:0]  abs_addr,
  output logic              sel_ctrl,
  output logic              sel_dma,
  output logic              sel_ireg,
  output logic              sel_breg,
  output logic              map_miss,
  output logic              fixed_vld,
  output logic [7:0]        fixed_data
);
  localparam int OFS_W  = 12;
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int PIDX_W = 10;

  region_e           region;
  logic [PIDX_W-1:0] pidx;
  atgt_e             atgt;
  logic [4:0]        oh_d;
  memtype_e          type_d;
  logic [ABS_W-1:0]  abs_d;
  logic              access, is_reg, is_none;

  sbd_page_map #(
    .PAGE_W(PAGE_W), .PIDX_W(PIDX_W), .WRAM_BANK(WRAM_BANK),
    .SRAM_BANK(SRAM_BANK), .SRAM_PAGES(SRAM_PAGES), .ROM_PAGES(ROM_PAGES)
  ) u_map (
    .page  (bus_addr[ADDR_W-1:OFS_W]),
    .region(region),
    .pidx  (pidx)
  );

  sbd_abus_split u_asplit (
    .off  (bus_addr[15:0]),
    .is_wr(bus_wr),
    .tgt  (atgt)
  );

  for (genvar g = 1; g <= NUM_RG; g++) begin : g_oh
    assign oh_d[g-1] = (region == region_e'(g));
  end

  always_comb begin
    case (region)
      RG_WRAM: type_d = MT_WRAM;
      RG_ROM:  type_d = MT_ROM;
      RG_SRAM: type_d = MT_SRAM;
      default: type_d = MT_CPU;
    endcase
  end

  assign abs_d   = (type_d == MT_CPU) ? '1 : ABS_W'({pidx, bus_addr[OFS_W-1:0]});
  assign access  = (bus_rd | bus_wr) & ~bus_peek;
  assign is_reg  = (region == RG_BREG) | (region == RG_AREG);
  assign is_none = (region == RG_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      region_oh   <= '0;
      region_type <= '0;
      abs_addr    <= '0;
      sel_ctrl    <= 1'b0;
      sel_dma     <= 1'b0;
      sel_ireg    <= 1'b0;
      sel_breg    <= 1'b0;
      map_miss    <= 1'b0;
      fixed_vld   <= 1'b0;
      fixed_data  <= '0;
    end else begin
      region_oh   <= oh_d;
      region_type <= type_d;
      abs_addr    <= abs_d;
      sel_ctrl    <= access && region == RG_AREG && atgt == AT_CTRL;
      sel_dma     <= access && region == RG_AREG && atgt == AT_DMA;
      sel_ireg    <= access && region == RG_AREG && atgt == AT_IREG;
      sel_breg    <= access && region == RG_BREG;
      map_miss    <= access && is_none;
      if (bus_peek && (is_reg || is_none)) begin
        fixed_vld  <= 1'b1;
        fixed_data <= 8'h00;
      end else if (bus_rd && !bus_peek && is_none) begin
        fixed_vld  <= 1'b1;
        fixed_data <= bus_addr[19:12];
      end else begin
        fixed_vld  <= 1'b0;
        fixed_data <= 8'h00;
      end
    end
  end

endmodule

// File: rtl/sbd_checker.sv
module sbd_checker (
  input logic        clk,
  input logic        rst,
  input logic [23:0] bus_addr,
  input logic        bus_peek,
  input logic [4:0]  region_oh,
  input logic [1:0]  region_type,
  input logic [31:0] abs_addr,
  input logic        sel_ctrl,
  input logic        sel_dma,
  input logic        sel_ireg,
  input logic        sel_breg,
  input logic        map_miss
);
  assert_region_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(region_oh));

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_ctrl, sel_dma, sel_ireg, sel_breg}));

  assert_miss_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
    map_miss |-> (region_oh == 5'd0 && abs_addr == 32'hFFFF_FFFF));

  assert_peek_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    bus_peek |=> !(sel_ctrl || sel_dma || sel_ireg || sel_breg || map_miss));

  assert_wram_type_R1: assert property (@(posedge clk) disable iff (rst)
    (region_type == 2'd1) |-> region_oh[0]);

  assert_abs_low_R10: assert property (@(posedge clk) disable iff (rst)
    (region_type != 2'd0) |-> abs_addr[11:0] == $past(bus_addr[11:0]));

  assert_asel_window_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_ctrl || sel_dma || sel_ireg) |-> region_oh[2]);

  assert_breg_window_R3: assert property (@(posedge clk) disable iff (rst)
    sel_breg |-> (region_oh[1] && abs_addr == 32'hFFFF_FFFF));
endmodule

bind sysbus_page_decoder sbd_checker u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_peek(bus_peek),
  .region_oh(region_oh), .region_type(region_type), .abs_addr(abs_addr),
  .sel_ctrl(sel_ctrl), .sel_dma(sel_dma), .sel_ireg(sel_ireg),
  .sel_breg(sel_breg), .map_miss(map_miss)
);

// File: tb/sysbus_page_decoder_test.sv
module sysbus_page_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_peek = 1'b0;
  logic [4:0]  region_oh;
  logic [1:0]  region_type;
  logic [31:0] abs_addr;
  logic        sel_ctrl, sel_dma, sel_ireg, sel_breg, map_miss, fixed_vld;
  logic [7:0]  fixed_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sysbus_page_decoder uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_peek(bus_peek), .region_oh(region_oh),
    .region_type(region_type), .abs_addr(abs_addr), .sel_ctrl(sel_ctrl),
    .sel_dma(sel_dma), .sel_ireg(sel_ireg), .sel_breg(sel_breg),
    .map_miss(map_miss), .fixed_vld(fixed_vld), .fixed_data(fixed_data)
  );

  function automatic logic [52:0] actual();
    return {region_oh, region_type, abs_addr, sel_ctrl, sel_dma, sel_ireg,
            sel_breg, map_miss, fixed_vld, fixed_data};
  endfunction

  // Reference from the requirements: region 0 none,1 wram,2 B,3 A,4 rom,5 sram
  function automatic logic [52:0] expect_of(logic [23:0] a, bit rd, bit wr, bit pk);
    logic [7:0] bank = a[23:16];
    logic [15:0] off = a[15:0];
    int rg = 0;
    logic [31:0] ab = 32'hFFFF_FFFF;
    logic [1:0] ty = 0;
    logic [4:0] oh = 0;
    bit acc = (rd || wr) && !pk;
    bit c = 0, d = 0, ir = 0, br = 0, ms = 0, fv = 0;
    logic [7:0] fd = 0;
    if (bank == 8'h7E || bank == 8'h7F) begin rg = 1; ab = {15'd0, a[16:0]}; end
    else if (bank <= 8'h3F || (bank >= 8'h80 && bank <= 8'hBF)) begin
      if (off < 16'h2000) begin rg = 1; ab = {16'd0, off}; end
      else if (off < 16'h3000) rg = 2;
      else if (off >= 16'h4000 && off < 16'h5000) rg = 3;
    end
    else if (bank == 8'h70 && off < 16'h8000) begin rg = 5; ab = {16'd0, off}; end
    else if (bank >= 8'hC0) begin rg = 4; ab = {10'd0, a[21:0]}; end
    ty = (rg == 1) ? 2'd1 : (rg == 4) ? 2'd2 : (rg == 5) ? 2'd3 : 2'd0;
    if (rg != 0) oh = 5'(1 << (rg - 1));
    if (acc && rg == 3) begin
      if (wr) begin
        if (off == 16'h4016) c = 1;
        else if (off == 16'h420B || off == 16'h420C || off >= 16'h4300) d = 1;
        else ir = 1;
      end else begin
        if (off == 16'h4016 || off == 16'h4017) c = 1;
        else if (off >= 16'h4300) d = 1;
        else ir = 1;
      end
    end
    br = acc && rg == 2;
    ms = acc && rg == 0;
    if (pk && (rg == 0 || rg == 2 || rg == 3)) fv = 1;
    else if (rd && !pk && rg == 0) begin fv = 1; fd = a[19:12]; end
    return {oh, ty, ab, c, d, ir, br, ms, fv, fd};
  endfunction

  function automatic string req_of(logic [23:0] a, bit rd, bit wr, bit pk);
    logic [7:0] bank = a[23:16];
    logic [15:0] off = a[15:0];
    if (pk) return "R9";
    if (bank == 8'h7E || bank == 8'h7F) return "R1";
    if (bank <= 8'h3F || (bank >= 8'h80 && bank <= 8'hBF)) begin
      if (off < 16'h2000) return "R2";
      if (off < 16'h3000) return "R3";
      if (off >= 16'h4000 && off < 16'h5000) return (wr ? "R5" : "R4");
      return "R8";
    end
    if (bank == 8'h70 && off < 16'h8000) return "R7";
    if (bank >= 8'hC0) return "R6";
    return "R8";
  endfunction

  task automatic check(bit ok, string req, logic [52:0] act, logic [52:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access; outputs registered, so sample just after the next rising edge (R10)
  task automatic access(logic [23:0] a, bit rd, bit wr, bit pk);
    logic [52:0] exp;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_peek = pk;
    exp = expect_of(a, rd, wr, pk);
    @(posedge clk);
    #1;
    check(actual() === exp, req_of(a, rd, wr, pk), actual(), exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check(actual() === 53'd0, "R10", actual(), 53'd0);  // reset state, R10
    @(negedge clk);
    rst = 1'b0;

    // R1/R2 work RAM and mirror edges, bank groups edges
    access(24'h7E0000, 1, 0, 0);
    access(24'h7FFFFF, 1, 0, 0);
    access(24'h001FFF, 1, 0, 0);
    access(24'h3F0800, 0, 1, 0);
    access(24'hBF1234, 1, 0, 0);
    // R3 B window and gap
    access(24'h802000, 0, 1, 0);
    access(24'h3F2FFF, 1, 0, 0);
    access(24'h003000, 1, 0, 0);
    // R4 / R5 A window splits
    access(24'h004016, 1, 0, 0);
    access(24'h004017, 1, 0, 0);
    access(24'h004017, 0, 1, 0);
    access(24'h80420B, 0, 1, 0);
    access(24'h00420C, 1, 0, 0);
    access(24'h00420A, 0, 1, 0);
    access(24'h004300, 1, 0, 0);
    access(24'h004FFF, 0, 1, 0);
    // R6 / R7 cartridge
    access(24'hC00000, 1, 0, 0);
    access(24'hFFFFFF, 1, 0, 0);
    access(24'h707FFF, 0, 1, 0);
    access(24'h708000, 1, 0, 0);
    // R8 unmapped
    access(24'h402345, 1, 0, 0);
    access(24'h005000, 0, 1, 0);
    access(24'h7D9000, 0, 0, 0);
    // R9 peeks
    access(24'h002000, 1, 0, 1);
    access(24'h004016, 0, 0, 1);
    access(24'h503000, 0, 0, 1);
    access(24'h7E1234, 0, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] bank;
      logic [15:0] off;
      int sel = $urandom % 7;
      int op  = $urandom % 4;
      off = 16'($urandom);
      case (sel)
        0: bank = 8'($urandom);
        1: bank = 8'($urandom % 64);
        2: bank = 8'h80 + 8'($urandom % 64);
        3: bank = 8'h7E + 8'($urandom % 2);
        4: bank = 8'h70;
        5: bank = 8'hC0 + 8'($urandom % 64);
        default: begin bank = 8'($urandom % 64); off = 16'h4000 + 16'($urandom % 16'h1000); end
      endcase
      if ($urandom % 4 == 0) off = {off[15:8], 8'h16 + 8'($urandom % 2)};
      access({bank, off}, op == 1, op == 2, op == 3);
    end

    // reset again mid-run, R10
    @(negedge clk);
    rst = 1'b1; bus_addr = 24'h004016; bus_rd = 1'b1;
    @(posedge clk);
    #1;
    check(actual() === 53'd0, "R10", actual(), 53'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule